// File: doc/BRIEF.md
# Table-free offset-binary distributed-arithmetic FIR filter

This block is a K-tap FIR filter with fixed coefficients. It computes each output bit-serially over one frame of B clock cycles, where B is the sample width. It uses the offset-binary form of distributed arithmetic. Each sample bit is read as +1 or -1 instead of 1 or 0. Each tap then contributes either plus or minus half of its coefficient, and no lookup table is needed. A constant correction term, equal to minus half the coefficient sum, is added once per frame on the least significant bit cycle. All halved quantities are carried with one extra fractional bit, so every intermediate value is an exact integer.

The taps are grouped into base units of `UNIT_TAPS` taps each. Every base unit forms its own signed partial sum and adds its own share of the correction term. A single shared shift-accumulator then combines the partial sums. Its add/subtract choice depends only on the frame position: it adds on every bit cycle except the most significant one, where it subtracts. Bits are consumed least significant first. The running value is halved each cycle, and fractional guard bits keep that halving lossless. A new sample is accepted whenever the block is idle or in the last bit cycle of a frame. A steady input stream therefore yields one full-precision result every B cycles.

Top module: `da_obc_fir`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` is 0, `out_y` is 0 and `in_ready` is 1.
- R2: Each result equals the exact sum over i of w_i times x[n-i], for every input in the two's complement range, including -2^(B-1). Tap 0 is the newest sample. Coefficient w_i is the signed field `COEFS[i*COEF_W +: COEF_W]`, and `out_y` is a signed two's complement value.
- R3: `out_valid` is high for exactly one cycle. It rises on the B-th rising clock edge after the edge that accepted the sample, and it is low in the cycles between.
- R4: `in_ready` is low during a frame except in its last bit cycle. An `in_valid` pulse while `in_ready` is low is ignored: that sample never enters the tap history.
- R5: When `in_valid` is held high, a sample is accepted every B cycles. A result follows every B cycles, each for the sample accepted one frame earlier.
- R6: `out_y` keeps its value in every cycle where `out_valid` is low.
- R7: After reset the tap history is all zero, so the first result equals w_0 times the first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Offers `in_sample` for acceptance |
| in_sample | input | DATA_W | Two's complement input sample |
| in_ready | output | 1 | High when a sample offered now is accepted |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_y | output | Y_W | Signed full-precision filter result |

## Verification
Assertions check on every cycle that:
- the tap history stays frozen when no sample is accepted;
- each base-unit partial sum stays within twice the absolute coefficient sum;
- the accumulator's final value is always an even integer with no fractional residue;
- the first-bit and last-bit controls never coincide;
- the result pulse lasts a single cycle;
- the result holds between pulses.

Only the bench scenarios can show the rest: that the numeric result matches the direct dot product, including the most negative sample; that the tap order is correct; that pulses arrive exactly B edges after acceptance; and that inputs offered mid-frame leave no trace on later results.

// File: rtl/da_obc_pkg.sv
package da_obc_pkg;

    // Frame sequencer phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/da_tap_line.sv
// Sample history for all taps, with bit-serial readout of one bit plane.
module da_tap_line #(
    parameter int DATA_W = 8,
    parameter int TAPS   = 8,
    localparam int SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] sample_in,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic [TAPS-1:0]   plane_bits
);

    typedef struct packed {
        logic [TAPS-1:0][DATA_W-1:0] taps;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (shift_en) begin
            for (int i = TAPS - 1; i > 0; i--) begin
                line_d.taps[i] = line_q.taps[i-1];
            end
            line_d.taps[0] = sample_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_plane
        assign plane_bits[g] = line_q.taps[g][bit_sel];
    end

    AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(line_q)); // R4

endmodule

// File: rtl/da_sign_unit.sv
// Base unit: per-tap sign-controlled coefficient terms plus the local offset.
// Values are doubled: a term of +/-w stands for +/-w/2 with one fraction bit.
module da_sign_unit #(
    parameter int COEF_W    = 10,
    parameter int UNIT_TAPS = 4,
    parameter int UNIT_W    = COEF_W + $clog2(UNIT_TAPS) + 2,
    parameter logic [UNIT_TAPS*COEF_W-1:0] UCOEF = '0
) (
    input  logic [UNIT_TAPS-1:0]     tap_bits,
    input  logic                     lsb_phase,
    output logic signed [UNIT_W-1:0] unit_sum
);

    function automatic logic signed [UNIT_W-1:0] offset_twice();
        logic signed [UNIT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < UNIT_TAPS; i++) begin
            acc = acc - UNIT_W'($signed(UCOEF[i*COEF_W +: COEF_W]));
        end
        return acc;
    endfunction

    function automatic logic signed [UNIT_W-1:0] magnitude_bound();
        logic signed [UNIT_W-1:0] acc;
        logic signed [UNIT_W-1:0] w;
        acc = '0;
        for (int i = 0; i < UNIT_TAPS; i++) begin
            w   = UNIT_W'($signed(UCOEF[i*COEF_W +: COEF_W]));
            acc = acc + ((w < 0) ? -w : w);
        end
        return acc + acc;
    endfunction

    localparam logic signed [UNIT_W-1:0] OFFSET2 = offset_twice();
    localparam logic signed [UNIT_W-1:0] BOUND   = magnitude_bound();

    logic signed [UNIT_W-1:0] term [UNIT_TAPS];

    for (genvar g = 0; g < UNIT_TAPS; g++) begin : g_term
        localparam logic signed [UNIT_W-1:0] WEXT =
            UNIT_W'($signed(UCOEF[g*COEF_W +: COEF_W]));
        assign term[g] = tap_bits[g] ? WEXT : -WEXT;
    end

    always_comb begin
        unit_sum = lsb_phase ? OFFSET2 : '0;
        for (int i = 0; i < UNIT_TAPS; i++) begin
            unit_sum = unit_sum + term[i];
        end
        AST_UNIT_RANGE: assert (unit_sum <= BOUND && unit_sum >= -BOUND); // R2
    end

endmodule

// File: rtl/da_shift_accum.sv
// Shared shift-accumulator: add (or subtract on the MSB cycle), then halve.
// DATA_W guard fraction bits keep the halving exact; the final value is 2*y.
module da_shift_accum #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 16,
    parameter int Y_W    = 21,
    localparam int ACC_W = SUM_W + DATA_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    first,
    input  logic                    last,
    input  logic signed [SUM_W-1:0] sum_in,
    output logic                    y_valid,
    output logic [Y_W-1:0]          y_out
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [Y_W-1:0]   y;
        logic             valid;
    } acc_t;

    acc_t st_d, st_q;

    logic signed [ACC_W-1:0] term_aligned;
    logic signed [ACC_W-1:0] base_val;
    logic signed [ACC_W-1:0] pre_val;
    logic signed [ACC_W-1:0] result_val;

    always_comb begin
        term_aligned = {{(ACC_W-SUM_W){sum_in[SUM_W-1]}}, sum_in} <<< DATA_W;
        base_val     = first ? '0 : $signed(st_q.acc);
        pre_val      = last ? (base_val - term_aligned) : (base_val + term_aligned);
        result_val   = pre_val >>> 2;

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (run) begin
            st_d.acc = pre_val >>> 1;
            if (last) begin
                st_d.y     = result_val[Y_W-1:0];
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_valid = st_q.valid;
    assign y_out   = st_q.y;

    AST_EXACT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last) |-> (pre_val[1:0] == 2'b00)); // R2
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid); // R3

endmodule

// File: rtl/da_obc_fir.sv
module da_obc_fir
    import da_obc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int COEF_W    = 10,
    parameter int TAPS      = 8,
    parameter int UNIT_TAPS = 4,
    parameter logic [TAPS*COEF_W-1:0] COEFS = {
        10'h001, 10'h07B, 10'h338, 10'h025,
        10'h3FF, 10'h000, 10'h1FF, 10'h200},
    localparam int Y_W = COEF_W + DATA_W + $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              in_ready,
    output logic              out_valid,
    output logic [Y_W-1:0]    out_y
);

    localparam int UNITS  = TAPS / UNIT_TAPS;
    localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int UNIT_W = COEF_W + $clog2(UNIT_TAPS) + 2;
    localparam int SUM_W  = UNIT_W + $clog2(UNITS) + 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic seq_first;
    logic seq_last;
    logic accept;

    always_comb begin
        seq_first = (seq_q.phase == PH_RUN) && (seq_q.cnt == '0);
        seq_last  = (seq_q.phase == PH_RUN) && (seq_q.cnt == LAST_CNT);
        in_ready  = (seq_q.phase == PH_IDLE) || seq_last;
        accept    = in_valid && in_ready;

        seq_d = seq_q;
        if (accept) begin
            seq_d.phase = PH_RUN;
            seq_d.cnt   = '0;
        end else if (seq_last) begin
            seq_d.phase = PH_IDLE;
            seq_d.cnt   = '0;
        end else if (seq_q.phase == PH_RUN) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    logic [TAPS-1:0] plane_bits;

    da_tap_line #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS)
    ) u_taps (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (accept),
        .sample_in  (in_sample),
        .bit_sel    (seq_q.cnt),
        .plane_bits (plane_bits)
    );

    logic signed [UNIT_W-1:0] unit_sum [UNITS];

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        da_sign_unit #(
            .COEF_W    (COEF_W),
            .UNIT_TAPS (UNIT_TAPS),
            .UNIT_W    (UNIT_W),
            .UCOEF     (COEFS[u*UNIT_TAPS*COEF_W +: UNIT_TAPS*COEF_W])
        ) u_unit (
            .tap_bits  (plane_bits[u*UNIT_TAPS +: UNIT_TAPS]),
            .lsb_phase (seq_first),
            .unit_sum  (unit_sum[u])
        );
    end

    logic signed [SUM_W-1:0] global_sum;

    always_comb begin
        global_sum = '0;
        for (int u = 0; u < UNITS; u++) begin
            global_sum = global_sum + SUM_W'(unit_sum[u]);
        end
    end

    da_shift_accum #(
        .DATA_W (DATA_W),
        .SUM_W  (SUM_W),
        .Y_W    (Y_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (seq_q.phase == PH_RUN),
        .first   (seq_first),
        .last    (seq_last),
        .sum_in  (global_sum),
        .y_valid (out_valid),
        .y_out   (out_y)
    );

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_first, seq_last})); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_y)); // R6

endmodule

// File: tb/da_obc_fir_bench.sv
module da_obc_fir_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 10;
    localparam int NT = 8;
    localparam int UT = 4;
    localparam int YW = CW + DW + $clog2(NT);
    localparam logic [NT*CW-1:0] COEFS = {
        10'h001, 10'h07B, 10'h338, 10'h025,
        10'h3FF, 10'h000, 10'h1FF, 10'h200};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          in_ready;
    logic          out_valid;
    logic [YW-1:0] out_y;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    longint hist [NT];

    always #(CLK_PERIOD/2) clk = ~clk;

    da_obc_fir #(
        .DATA_W    (DW),
        .COEF_W    (CW),
        .TAPS      (NT),
        .UNIT_TAPS (UT),
        .COEFS     (COEFS)
    ) u_da_obc_fir (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    function automatic longint coef(int i);
        return longint'($signed(COEFS[i*CW +: CW]));
    endfunction

    function automatic longint model();
        longint s = 0;
        for (int i = 0; i < NT; i++) s += coef(i) * hist[i];
        return s;
    endfunction

    function automatic longint yval();
        return longint'($signed(out_y));
    endfunction

    task automatic push(logic [DW-1:0] x);
        for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'($signed(x));
    endtask

    task automatic check_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One isolated frame; optionally pokes in_valid while busy.
    task automatic frame(logic [DW-1:0] x, bit poke);
        longint exp;
        longint held;
        @(negedge clk);
        check_eq("R4 ready when idle", longint'(in_ready), 1);
        in_valid  = 1'b1;
        in_sample = x;
        @(posedge clk);
        push(x);
        exp = model();
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < DW; k++) begin
            if (k > 0) @(negedge clk);
            check_eq("R3 no early valid", longint'(out_valid), 0);
            if (k < DW - 1) check_eq("R4 busy mid-frame", longint'(in_ready), 0);
            if (poke && k == 1) begin
                in_valid  = 1'b1;
                in_sample = ~x;
            end
            if (poke && k == 2) in_valid = 1'b0;
        end
        @(negedge clk);
        check_eq("R3 valid on B-th edge", longint'(out_valid), 1);
        check_eq("R2 result", yval(), exp);
        held = yval();
        @(negedge clk);
        check_eq("R3 pulse ends", longint'(out_valid), 0);
        check_eq("R6 result held", yval(), held);
    endtask

    // Back-to-back stream with in_valid held high.
    task automatic burst(int n, bit extreme);
        longint prev_exp = 0;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = extreme ? 8'h80 : DW'($urandom);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            push(in_sample);
            @(negedge clk);
            if (i > 0) begin
                check_eq("R5 stream valid", longint'(out_valid), 1);
                check_eq("R5 stream result", yval(), prev_exp);
            end else begin
                check_eq("R5 stream start", longint'(out_valid), 0);
            end
            prev_exp = model();
            if (i < n - 1) in_sample = extreme ? ((i % 2 == 0) ? 8'h7F : 8'h80) : DW'($urandom);
            else in_valid = 1'b0;
            for (int k = 1; k < DW; k++) begin
                @(negedge clk);
                check_eq("R5 spacing", longint'(out_valid), 0);
            end
        end
        @(negedge clk);
        check_eq("R5 final valid", longint'(out_valid), 1);
        check_eq("R5 final result", yval(), prev_exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (2000 * DW * 4) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NT; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset valid", longint'(out_valid), 0);
        check_eq("R1 reset y", yval(), 0);
        check_eq("R1 reset ready", longint'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 post-reset valid", longint'(out_valid), 0);
        check_eq("R1 post-reset ready", longint'(in_ready), 1);

        frame(8'h05, 1'b0);
        check_eq("R7 first output", yval(), coef(0) * 5);

        for (int i = 0; i < NT; i++) frame(8'h80, 1'b0);   // most negative
        for (int i = 0; i < NT; i++) frame(8'h7F, 1'b0);   // most positive
        for (int i = 0; i < NT; i++) frame((i % 2 == 0) ? 8'h80 : 8'h7F, 1'b0);
        for (int i = 0; i < NT; i++) frame(8'h00, 1'b0);
        frame(8'hFF, 1'b0);
        frame(8'h01, 1'b0);
        frame(8'h40, 1'b1);
        frame(8'hC3, 1'b1);

        for (int i = 0; i < 60; i++) frame(DW'($urandom), ($urandom % 3) == 0);

        burst(20, 1'b0);
        burst(10, 1'b1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule